// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of translation tables from memory. A requester hands it a virtual address, a flag saying whether the access is a store, and a flag saying whether the requester runs in supervisor mode. Software loads a base register that points at the top-level table, the directory, for the current address space. The walker first reads the directory entry for the address. It then reads the entry in the second-level table that the directory entry points to. Finally it returns the page's base joined with the byte offset.

Every entry is checked before the walk goes on. The walk stops with a page fault if an entry is absent, if the access is a store to a read-only mapping, or if user code touches a supervisor-only mapping. On a fault the block latches the faulting address, the access type and the mode, and it raises an interrupt line that carries a fixed vector. When an entry passes its checks, the block writes the entry back to memory to set the accessed flag, and for a store it also sets the dirty flag in the final entry. Requests and responses use a valid/ready handshake, and only one walk is in progress at a time. The memory port holds each word access until the memory acknowledges it, so any memory latency works.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from the word address formed by bits 31:12 of the base register, then virtual address bits 31:22, then two zero bits. Base register bits 11:0 are ignored.
- R2: The second-level entry is read from the word address formed by directory entry bits 31:12, then virtual address bits 21:12, then two zero bits. A successful response returns second-level entry bits 31:12 joined with virtual address bits 11:0.
- R3: Entry bit 0 means present. An entry with bit 0 clear stops the walk with a fault whose absent flag is 1, whatever its other bits hold, and no write is made to memory.
- R4: Entry bit 1 means writable and bit 2 means supervisor-only. A store through an entry with bit 1 clear faults at either level, in either mode. A user-mode access through an entry with bit 2 set faults. Supervisor mode is not restricted by bit 2. Such faults have an absent flag of 0.
- R5: A faulting response has rsp_fault=1 and rsp_paddr=0. The fault address, store flag and supervisor flag hold the values of the faulting request until the next fault. flt_irq is high for exactly the first cycle of the faulting response. flt_vector reads 14.
- R6: An entry that passes its checks and has the accessed bit (bit 5) clear is written back with bit 5 set before the walk goes on. An entry that already has the needed bits set is not written.
- R7: On a successful store, the final entry is written back with the dirty bit (bit 6) set. The dirty bit is never set in a directory entry, and it is not set on a load.
- R8: A pulse on base_we loads base_wdata into the base register. Walks accepted afterwards use the new base. A walk already in progress keeps the base it started with.
- R9: req_ready is high only while no walk is in progress. A response stays valid, with paddr and fault outputs stable, until rsp_ready is high.
- R10: mem_req stays high with a word-aligned address and a stable direction and write data until mem_ack. The result of a walk does not depend on memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load strobe for the directory base register |
| base_wdata | input | 32 | New directory base (bits 11:0 ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_super | input | 1 | Access comes from supervisor mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester accepts the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_fault_absent | output | 1 | Fault came from a not-present entry |
| flt_vaddr | output | 32 | Virtual address of the latest fault |
| flt_write | output | 1 | Latest fault was a store |
| flt_super | output | 1 | Latest fault came from supervisor mode |
| flt_irq | output | 1 | One-cycle fault interrupt |
| flt_vector | output | 8 | Interrupt vector number |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench sets a base with nonzero low bits. A walker that did not mask them would read the wrong directory word and return a wrong physical address. Absent entries are filled with stray flag bits such as writable and accessed. A design that looked at those bits would write the entry back or report a protection fault instead of an absent one. Read-only and supervisor-only mappings are tried at each level and in both modes. Here a wrong check shows up either as a translation returned where a fault was due, or as an accessed or dirty bit appearing on an entry that should stay untouched. The bench also switches the base between address spaces, changes memory latency and holds back the response. These expose a design that drops the base update, depends on latency, or lets its outputs change while the response waits.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int DIR_W = 10;
  localparam int TBL_W = 10;
  localparam int OFF_W = 12;
  localparam int VA_W  = DIR_W + TBL_W + OFF_W;
  localparam int ENT_W = VA_W;
  localparam int FRAME_W = VA_W - OFF_W;

  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_S = 2;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WR_DIR,
    ST_RD_TBL,
    ST_WR_TBL,
    ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE,
    FLT_ABSENT,
    FLT_PROT
  } flt_kind_e;

  // word address of a directory entry
  function automatic logic [VA_W-1:0] dir_entry_addr(input logic [VA_W-1:0] base,
                                                     input logic [VA_W-1:0] va);
    return {base[VA_W-1:OFF_W], va[VA_W-1:TBL_W+OFF_W], 2'b00};
  endfunction

  // word address of a second-level entry
  function automatic logic [VA_W-1:0] tbl_entry_addr(input logic [ENT_W-1:0] pde,
                                                     input logic [VA_W-1:0] va);
    return {pde[ENT_W-1:OFF_W], va[TBL_W+OFF_W-1:OFF_W], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(input logic [ENT_W-1:0] pte,
                                                input logic [VA_W-1:0] va);
    return {pte[ENT_W-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  // absence beats protection; store needs W in any mode; user needs S clear
  function automatic flt_kind_e entry_fault(input logic [ENT_W-1:0] e,
                                            input logic wr, input logic sup);
    if (!e[BIT_P]) return FLT_ABSENT;
    if (wr && !e[BIT_W]) return FLT_PROT;
    if (!sup && e[BIT_S]) return FLT_PROT;
    return FLT_NONE;
  endfunction

  function automatic logic [ENT_W-1:0] mark_entry(input logic [ENT_W-1:0] e,
                                                  input logic wr, input logic leaf);
    logic [ENT_W-1:0] m;
    m = e;
    m[BIT_A] = 1'b1;
    if (wr && leaf) m[BIT_D] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg
  import pt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [VA_W-1:0] wdata,
  output logic [VA_W-1:0] base
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else if (we) frame_q <= wdata[VA_W-1:OFF_W];
  end

  assign base = {frame_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_super,
  input  logic             is_leaf,
  output flt_kind_e        kind,
  output logic [ENT_W-1:0] marked,
  output logic             need_wb
);
  always_comb begin
    kind    = entry_fault(entry, is_write, is_super);
    marked  = mark_entry(entry, is_write, is_leaf);
    need_wb = (marked != entry);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [VA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_super,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_fault_absent,
  output logic [VA_W-1:0]  flt_vaddr,
  output logic             flt_write,
  output logic             flt_super,
  output logic             flt_irq,
  output logic [VEC_W-1:0] flt_vector,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata
);
  walk_st_e         state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic             sup_q;
  logic [VA_W-1:0]  walk_base_q;
  logic [ENT_W-1:0] pde_q;
  logic [ENT_W-1:0] pte_q;
  logic [VA_W-1:0]  paddr_q;
  logic             fault_q;
  logic             absent_q;
  logic [VA_W-1:0]  flt_va_q;
  logic             flt_wr_q;
  logic             flt_sup_q;
  logic             irq_q;
  logic [VA_W-1:0]  cur_base;

  flt_kind_e        chk_kind;
  logic [ENT_W-1:0] chk_marked;
  logic             chk_need_wb;

  // named internal events
  logic in_read;
  logic ev_accept;
  logic ev_fault;
  logic ev_done;

  pt_base_reg u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (base_we),
    .wdata(base_wdata),
    .base (cur_base)
  );

  pt_entry_check u_check (
    .entry   (mem_rdata),
    .is_write(wr_q),
    .is_super(sup_q),
    .is_leaf (state_q == ST_RD_TBL),
    .kind    (chk_kind),
    .marked  (chk_marked),
    .need_wb (chk_need_wb)
  );

  assign in_read   = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL);
  assign ev_accept = req_valid && req_ready;
  assign ev_fault  = mem_ack && in_read && (chk_kind != FLT_NONE);
  assign ev_done   = mem_ack && (((state_q == ST_RD_TBL) && (chk_kind == FLT_NONE) && !chk_need_wb)
                                 || (state_q == ST_WR_TBL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      sup_q       <= 1'b0;
      walk_base_q <= '0;
      pde_q       <= '0;
      pte_q       <= '0;
      paddr_q     <= '0;
      fault_q     <= 1'b0;
      absent_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            va_q        <= req_vaddr;
            wr_q        <= req_write;
            sup_q       <= req_super;
            walk_base_q <= cur_base;
            state_q     <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: begin
          if (mem_ack) begin
            if (chk_kind != FLT_NONE) begin
              fault_q  <= 1'b1;
              absent_q <= (chk_kind == FLT_ABSENT);
              paddr_q  <= '0;
              state_q  <= ST_RESP;
            end else begin
              pde_q   <= chk_marked;
              state_q <= chk_need_wb ? ST_WR_DIR : ST_RD_TBL;
            end
          end
        end
        ST_WR_DIR: begin
          if (mem_ack) state_q <= ST_RD_TBL;
        end
        ST_RD_TBL: begin
          if (mem_ack) begin
            if (chk_kind != FLT_NONE) begin
              fault_q  <= 1'b1;
              absent_q <= (chk_kind == FLT_ABSENT);
              paddr_q  <= '0;
              state_q  <= ST_RESP;
            end else begin
              pte_q    <= chk_marked;
              fault_q  <= 1'b0;
              absent_q <= 1'b0;
              paddr_q  <= phys_addr(mem_rdata, va_q);
              state_q  <= chk_need_wb ? ST_WR_TBL : ST_RESP;
            end
          end
        end
        ST_WR_TBL: begin
          if (mem_ack) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // fault record and interrupt pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_va_q  <= '0;
      flt_wr_q  <= 1'b0;
      flt_sup_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= ev_fault;
      if (ev_fault) begin
        flt_va_q  <= va_q;
        flt_wr_q  <= wr_q;
        flt_sup_q <= sup_q;
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_RD_DIR: begin
        mem_req  = 1'b1;
        mem_addr = dir_entry_addr(walk_base_q, va_q);
      end
      ST_WR_DIR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dir_entry_addr(walk_base_q, va_q);
        mem_wdata = pde_q;
      end
      ST_RD_TBL: begin
        mem_req  = 1'b1;
        mem_addr = tbl_entry_addr(pde_q, va_q);
      end
      ST_WR_TBL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tbl_entry_addr(pde_q, va_q);
        mem_wdata = pte_q;
      end
      default: ;
    endcase
  end

  assign req_ready        = (state_q == ST_IDLE);
  assign rsp_valid        = (state_q == ST_RESP);
  assign rsp_paddr        = paddr_q;
  assign rsp_fault        = fault_q;
  assign rsp_fault_absent = absent_q;
  assign flt_vaddr        = flt_va_q;
  assign flt_write        = flt_wr_q;
  assign flt_super        = flt_sup_q;
  assign flt_irq          = irq_q;
  assign flt_vector       = VEC_W'(FAULT_VEC);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VA_W-1:0]  rsp_paddr,
  input logic             rsp_fault,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [VA_W-1:0]  mem_addr,
  input logic [ENT_W-1:0] mem_wdata,
  input logic             flt_irq,
  input logic             ev_fault
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R9
  accept_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid && !req_ready);

  // R5
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> flt_irq && rsp_valid && rsp_fault);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_irq |=> !flt_irq);

  // R5
  fault_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R6
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_A] && mem_wdata[BIT_P]);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .flt_irq  (flt_irq),
  .ev_fault (ev_fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_absent;
  logic [31:0] flt_vaddr;
  logic        flt_write;
  logic        flt_super;
  logic        flt_irq;
  logic [7:0]  flt_vector;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_absent(rsp_fault_absent),
    .flt_vaddr(flt_vaddr), .flt_write(flt_write), .flt_super(flt_super),
    .flt_irq(flt_irq), .flt_vector(flt_vector),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: 16 KB, word indexed by address bits 13:2
  logic [31:0] mem [0:4095];
  int lat = 1;
  int cnt = 0;
  int wr_count = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_count <= wr_count + 1;
        end
        cnt <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // response capture
  logic [31:0] r_paddr;
  logic        r_fault, r_absent, r_irq;
  int          r_wr_delta;

  localparam logic [31:0] VA1  = 32'h00C0_5234; // dir 3, table 5, offset 0x234
  localparam int          PDE1 = 12'h403;       // 0x1000 + 3*4
  localparam int          PTE1 = 12'hC05;       // 0x3000 + 5*4

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit sup, input int hold);
    int w0;
    w0 = wr_count;
    @(negedge clk);
    req_vaddr = va;
    req_write = wr;
    req_super = sup;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = (hold == 0);
    while (!rsp_valid) @(negedge clk);
    r_paddr  = rsp_paddr;
    r_fault  = rsp_fault;
    r_absent = rsp_fault_absent;
    r_irq    = flt_irq;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      eq("R9 response held valid", {31'b0, rsp_valid}, 32'd1);
      eq("R9 paddr stable", rsp_paddr, r_paddr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    eq("R5 irq single cycle", {31'b0, flt_irq}, 32'd0);
    eq("R9 ready after response", {31'b0, req_ready}, 32'd1);
    r_wr_delta = wr_count - w0;
  endtask

  task automatic t_reset;
    eq("R9 reset req_ready", {31'b0, req_ready}, 32'd1);
    eq("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    eq("R10 reset mem_req", {31'b0, mem_req}, 32'd0);
    eq("R5 reset irq", {31'b0, flt_irq}, 32'd0);
    eq("R5 vector", {24'b0, flt_vector}, 32'd14);
  endtask

  task automatic t_load;
    mem[PDE1] = 32'h0000_3003;
    mem[PTE1] = 32'h0ABC_D001;
    walk(VA1, 1'b0, 1'b0, 0);
    eq("R1 R2 load paddr", r_paddr, 32'h0ABC_D234);
    eq("R2 load no fault", {31'b0, r_fault}, 32'd0);
    eq("R6 dir accessed set", mem[PDE1], 32'h0000_3023);
    eq("R6 R7 leaf accessed, no dirty on load", mem[PTE1], 32'h0ABC_D021);
  endtask

  task automatic t_store;
    mem[PTE1] = 32'h0ABC_D003;
    walk(VA1, 1'b1, 1'b0, 0);
    eq("R7 store paddr", r_paddr, 32'h0ABC_D234);
    eq("R7 dir has no dirty", mem[PDE1], 32'h0000_3023);
    eq("R7 leaf dirty+accessed", mem[PTE1], 32'h0ABC_D063);
    eq("R6 only leaf written", r_wr_delta, 32'd1);
    walk(VA1, 1'b1, 1'b0, 0);
    eq("R6 no write when bits set", r_wr_delta, 32'd0);
  endtask

  task automatic t_absent_dir;
    mem[PDE1] = 32'hFFFF_F0FE;
    walk(VA1, 1'b1, 1'b1, 0);
    eq("R3 dir absent fault", {31'b0, r_fault}, 32'd1);
    eq("R3 absent flag", {31'b0, r_absent}, 32'd1);
    eq("R5 fault paddr zero", r_paddr, 32'd0);
    eq("R5 fault vaddr", flt_vaddr, VA1);
    eq("R5 fault write", {31'b0, flt_write}, 32'd1);
    eq("R5 fault super", {31'b0, flt_super}, 32'd1);
    eq("R5 irq first cycle", {31'b0, r_irq}, 32'd1);
    eq("R3 absent entry untouched", mem[PDE1], 32'hFFFF_F0FE);
    eq("R3 no write on absent", r_wr_delta, 32'd0);
  endtask

  task automatic t_absent_tbl;
    mem[PDE1] = 32'h0000_3023;
    mem[PTE1] = 32'h0ABC_D0FE;
    walk(32'h00C0_5ABC, 1'b0, 1'b0, 0);
    eq("R3 leaf absent fault", {31'b0, r_fault & r_absent}, 32'd1);
    eq("R5 fault vaddr updated", flt_vaddr, 32'h00C0_5ABC);
    eq("R5 fault write clear", {31'b0, flt_write}, 32'd0);
    eq("R5 fault user", {31'b0, flt_super}, 32'd0);
    eq("R3 leaf absent untouched", mem[PTE1], 32'h0ABC_D0FE);
  endtask

  task automatic t_readonly;
    mem[PDE1] = 32'h0000_3003;
    mem[PTE1] = 32'h0ABC_D001;
    walk(VA1, 1'b1, 1'b1, 0);
    eq("R4 leaf read-only store faults", {31'b0, r_fault}, 32'd1);
    eq("R4 protection not absent", {31'b0, r_absent}, 32'd0);
    eq("R6 leaf not marked on fault", mem[PTE1], 32'h0ABC_D001);
    eq("R6 dir marked after its check", mem[PDE1], 32'h0000_3023);
    mem[PDE1] = 32'h0000_3021;
    mem[PTE1] = 32'h0ABC_D003;
    walk(VA1, 1'b1, 1'b0, 0);
    eq("R4 dir read-only store faults", {31'b0, r_fault}, 32'd1);
    eq("R4 dir fault leaves leaf", mem[PTE1], 32'h0ABC_D003);
  endtask

  task automatic t_super;
    mem[PDE1] = 32'h0000_3023;
    mem[PTE1] = 32'h0ABC_D027;
    walk(VA1, 1'b0, 1'b0, 0);
    eq("R4 user to supervisor page faults", {31'b0, r_fault}, 32'd1);
    eq("R4 supervisor fault is protection", {31'b0, r_absent}, 32'd0);
    walk(VA1, 1'b0, 1'b1, 0);
    eq("R4 supervisor allowed", {31'b0, r_fault}, 32'd0);
    eq("R4 supervisor paddr", r_paddr, 32'h0ABC_D234);
  endtask

  task automatic t_base_switch;
    mem[12'h803] = 32'h0000_0023;
    mem[12'h005] = 32'h0555_5001;
    set_base(32'h0000_2000);
    walk(VA1, 1'b0, 1'b1, 0);
    eq("R8 new space paddr", r_paddr, 32'h0555_5234);
    set_base(32'h0000_1FFF);
    walk(VA1, 1'b0, 1'b1, 0);
    eq("R1 R8 low base bits ignored", r_paddr, 32'h0ABC_D234);
  endtask

  task automatic t_midwalk_base;
    // base change during a walk: the walk keeps its base
    lat = 6;
    @(negedge clk);
    req_vaddr = VA1; req_write = 1'b0; req_super = 1'b1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    base_we = 1'b1; base_wdata = 32'h0000_2000;
    @(negedge clk);
    base_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    eq("R8 walk in progress keeps base", rsp_paddr, 32'h0ABC_D234);
    @(negedge clk);
    lat = 1;
    walk(VA1, 1'b0, 1'b1, 0);
    eq("R8 following walk uses new base", r_paddr, 32'h0555_5234);
    set_base(32'h0000_1000);
  endtask

  task automatic t_latency;
    lat = 0;
    walk(VA1, 1'b0, 1'b1, 0);
    eq("R10 zero latency", r_paddr, 32'h0ABC_D234);
    lat = 4;
    walk(VA1, 1'b0, 1'b1, 3);
    eq("R10 R9 slow memory with backpressure", r_paddr, 32'h0ABC_D234);
    lat = 1;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    set_base(32'h0000_1ABC);
    t_load;
    t_store;
    t_absent_dir;
    t_absent_tbl;
    t_readonly;
    t_super;
    t_base_switch;
    t_midwalk_base;
    t_latency;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule